// File: doc/BRIEF.md
# SPI master with status flags

This block is a register-mapped SPI master that moves one byte in both directions per transfer. A host, either the CPU or a DMA engine, uses one narrow bus with two registers. Writing the data register places a byte in a transmit holding buffer. When the shift engine is idle it takes that byte and starts a transfer. It shifts eight bits out on the serial output pin, most significant bit first, and samples eight bits from the serial input pin at the same time. A rate field in the control register selects the serial clock divider.

Two flags report progress. The transmit-empty flag shows that the holding buffer can take another byte. The receive-full flag shows that a completed byte is waiting in the receive register. Software clears the receive-full flag in two steps: it reads the status register while the flag is set, then it reads the data register. When the DMA-mode bit is set, the data read alone clears the flag.

A single engine FSM paces each bit. Its states are SH_IDLE (clock low, waiting for a buffered byte), SH_LOW (clock low, waiting for the half-period tick before the rising edge) and SH_HIGH (clock high, waiting for the tick before the falling edge). Its transitions are SH_IDLE→SH_LOW when a buffered byte is taken, SH_LOW→SH_HIGH on a tick, SH_HIGH→SH_LOW on a tick before the eighth bit, and SH_HIGH→SH_IDLE on the tick that ends the eighth bit.

Top module: `spim_top`

## Requirements
- R1: After reset the status register reads 8'h40: transmit-empty set and receive-full clear. The rate field is 00, DMA mode is off, the serial clock and serial output are low, and the data register reads 0.
- R2: A write to the data register (bus_sel=0) clears transmit-empty in the next cycle. If the engine is idle, the byte is taken one cycle later and transmit-empty returns to 1. If a transfer is in progress, transmit-empty stays 0 until the cycle after that transfer completes, when the buffered byte is taken.
- R3: Each transfer is mode 0 and MSB first. The serial clock idles low. The output bit changes only when a byte is taken or on a falling clock edge, and the input is sampled on each rising edge. The eight output bits equal the written byte, and the eight input bits form the received byte.
- R4: Rate codes 00, 01, 10 and 11 give a serial clock period of 2, 8, 32 and 128 bus clocks. Receive-full is set exactly 1+8·period cycles after the edge that accepts the data write, and not one cycle earlier.
- R5: On the clock edge that sets receive-full, the received byte appears in the data register (read with bus_sel=0).
- R6: With DMA mode off, a data-register read without a prior arming status read leaves receive-full set.
- R7: A status read (bus_sel=1) while receive-full is set arms the clear, and a following data read then clears receive-full. Every data read disarms, so a later data read with no new status read does not clear.
- R8: A status read made while receive-full is clear does not arm, so a data read after the byte completes leaves receive-full set.
- R9: With DMA mode on (control bit 4 = 1), a data read alone clears receive-full.
- R10: When a byte completes while receive-full is still set, the new byte replaces the receive register. The status then reads exactly 8'hC0 for rate 00 with DMA off, and carries no extra indication.
- R11: Writing the status/control address stores the rate in bits 1:0 and DMA mode in bit 4. The status read returns receive-full in bit 7, transmit-empty in bit 6, DMA mode in bit 4 and the rate in bits 1:0, with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 data, 1 status/control |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; side effects of a read happen on this strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Selected register, shown continuously |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions take three things for granted. Read and write strobes are never raised in the same cycle. The rate field is not rewritten while a transfer is running, so the tick spacing stays fixed within one byte. The serial input changes only after falling edges, never in the cycle of a rising edge. The stimulus raises each strobe alone for one cycle and changes the rate only while the engine is idle. Its slave model updates the serial input from the falling clock edge, so every sample taken on a rising edge sees a settled bit.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int STAT_W = 8;
    localparam int RATE_W = 2;
    localparam int ST_RXFULL  = 7;
    localparam int ST_TXEMPTY = 6;
    localparam int ST_DMA     = 4;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } sh_state_t;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    // half period = 4^rate bus clocks
    localparam int HALF_MAX = 1 << (2 * ((1 << RATE_W) - 1));
    localparam int CNT_W    = $clog2(HALF_MAX) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'((32'd1 << {rate, 1'b0}) - 32'd1);
        tick    = run && (cnt == half_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              take,
    output logic              done,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BIT_W = $clog2(DATA_W);

    sh_state_t         state, nxt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [BIT_W-1:0]  bit_cnt;
    logic              last;

    always_comb begin
        last = (bit_cnt == BIT_W'(DATA_W - 1));
        nxt  = state;
        unique case (state)
            SH_IDLE: if (load_req) nxt = SH_LOW;
            SH_LOW:  if (tick)     nxt = SH_HIGH;
            SH_HIGH: if (tick)     nxt = last ? SH_IDLE : SH_LOW;
            default:               nxt = SH_IDLE;
        endcase
        take = (state == SH_IDLE) && load_req;
        done = (state == SH_HIGH) && tick && last;
        busy = (state != SH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    if (load_req) begin
                        tx_sh   <= load_byte;
                        mosi    <= load_byte[DATA_W-1];
                        bit_cnt <= '0;
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        sck   <= 1'b1;
                        rx_sh <= {rx_sh[DATA_W-2:0], miso};
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        sck <= 1'b0;
                        if (last) begin
                            rx_byte <= rx_sh;
                        end else begin
                            tx_sh   <= tx_sh << 1;
                            mosi    <= tx_sh[DATA_W-2];
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: sck <= 1'b0;
            endcase
        end
    end

    // R4: the serial clock moves only after a divider tick
    a_r4_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> $past(tick));

    // R3: clock idles low whenever the engine is idle
    a_r3_sck_idles_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_IDLE) |-> !sck);

    // R3: output bit changes only on load or falling clock edge
    a_r3_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> ($fell(sck) || $past(take)));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              load_req,
    output logic [DATA_W-1:0] load_byte,
    output logic [RATE_W-1:0] rate,
    output logic              tx_empty,
    output logic              rx_full,
    output logic [DATA_W-1:0] rdata
);
    logic              wr_data, wr_ctl, rd_data, rd_stat;
    logic              dma_mode, armed, buf_full;
    logic [STAT_W-1:0] status;

    always_comb begin
        wr_data  = wr && !sel;
        wr_ctl   = wr && sel;
        rd_data  = rd && !sel;
        rd_stat  = rd && sel;
        tx_empty = !buf_full;
        load_req = buf_full;
        status   = '0;
        status[ST_RXFULL]  = rx_full;
        status[ST_TXEMPTY] = tx_empty;
        status[ST_DMA]     = dma_mode;
        status[RATE_W-1:0] = rate;
        rdata    = sel ? DATA_W'(status) : rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_full  <= 1'b0;
            load_byte <= '0;
        end else if (wr_data) begin
            buf_full  <= 1'b1;
            load_byte <= wdata;
        end else if (take) begin
            buf_full  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate     <= '0;
            dma_mode <= 1'b0;
        end else if (wr_ctl) begin
            rate     <= wdata[RATE_W-1:0];
            dma_mode <= wdata[ST_DMA];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (done)
                rx_full <= 1'b1;
            else if (rd_data && (dma_mode || armed))
                rx_full <= 1'b0;
            if (rd_data)
                armed <= 1'b0;
            else if (rd_stat && rx_full)
                armed <= 1'b1;
        end
    end

    // R6: receive-full falls only after a data read
    a_r6_fall_needs_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_data));

    // R7: without DMA mode, a clear needs a prior arming status read
    a_r7_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> ($past(dma_mode) || $past(armed)));
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              take, done, busy, tick;
    logic              load_req, tx_empty, rx_full;
    logic [DATA_W-1:0] load_byte, rx_byte;
    logic [RATE_W-1:0] rate;

    spim_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .take     (take),
        .done     (done),
        .rx_byte  (rx_byte),
        .load_req (load_req),
        .load_byte(load_byte),
        .rate     (rate),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .rdata    (bus_rdata)
    );

    spim_baud #(.RATE_W(RATE_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .rate (rate),
        .tick (tick)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .load_byte(load_byte),
        .tick     (tick),
        .miso     (spi_miso),
        .take     (take),
        .done     (done),
        .busy     (busy),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .rx_byte  (rx_byte)
    );

    // R5: the completing edge leaves receive-full set
    a_r5_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);

    // R2: a handoff with no new write frees the buffer
    a_r2_handoff_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(bus_wr && !bus_sel)) |=> tx_empty);
endmodule

// File: tb/spim_top_tb.sv
`timescale 1ns/1ps
module spim_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi, spi_miso;

    int  n_total = 0, n_pass = 0;
    bit  finished = 0;

    // rate, tx byte, slave byte
    localparam logic [17:0] VEC [6] = '{
        {2'd0, 8'hA5, 8'h3C}, {2'd1, 8'h81, 8'hFF}, {2'd2, 8'h00, 8'h5A},
        {2'd3, 8'h7E, 8'hC3}, {2'd0, 8'hFF, 8'h00}, {2'd1, 8'h12, 8'h96}
    };

    always #2 clk = ~clk;

    spim_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // slave model: presents MSB first, advances after each falling edge
    logic [7:0] slave_next = '0;
    logic [7:0] sreg = '0;
    logic [2:0] scnt = '0;
    always @(negedge spi_sck) begin
        if (rst_n) begin
            if (scnt == 3'd0) sreg <= slave_next << 1;
            else              sreg <= sreg << 1;
            scnt <= scnt + 3'd1;
        end
    end
    assign spi_miso = (scnt == 3'd0) ? slave_next[7] : sreg[7];

    // pin monitor sampled away from the active edge
    logic       sck_q = 1'b0;
    logic [7:0] mcap = '0;
    int         cyc = 0, last_rise = 0, period = 0;
    always @(negedge clk) begin
        sck_q <= spi_sck;
        if (spi_sck && !sck_q) begin
            mcap      <= {mcap[6:0], spi_mosi};
            last_rise <= cyc;
            period    <= cyc - last_rise;
        end
        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act == exp) n_pass++;
        else $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    endtask

    task automatic cycles(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic bus_write(input logic s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic s);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic s, output logic [7:0] v);
        bus_sel = s;
        #1 v = bus_rdata;
    endtask

    // one transfer at half period h; pre = receive-full already set
    task automatic xfer(input int h, input logic [7:0] tx,
                        input logic [7:0] srx, input bit pre);
        logic [7:0] v;
        slave_next = srx;
        bus_write(1'b0, tx);
        peek(1'b1, v); chk("R2 empty cleared by write", v[6], 0);
        cycles(1);
        peek(1'b1, v); chk("R2 empty after handoff", v[6], 1);
        cycles(16 * h - 1);
        peek(1'b1, v); chk("R4 full not yet set", v[7], pre);
        cycles(1);
        peek(1'b1, v); chk("R4 full set on time", v[7], 1);
        peek(1'b0, v); chk("R5 received byte", v, srx);
        chk("R3 shifted out byte", mcap, tx);
        chk("R4 sck period", period, 2 * h);
    endtask

    task automatic clear_full();
        logic [7:0] v;
        bus_read(1'b1);
        bus_read(1'b0);
        peek(1'b1, v); chk("R7 cleared by status then data read", v[7], 0);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(1'b1, v); chk("R1 status after reset", v, 8'h40);
        peek(1'b0, v); chk("R1 data after reset", v, 0);
        chk("R1 sck low", spi_sck, 0);
        chk("R1 mosi low", spi_mosi, 0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            logic [1:0] rt;
            rt = VEC[i][17:16];
            bus_write(1'b1, {6'd0, rt});
            peek(1'b1, v); chk("R11 control readback", v, 8'h40 | rt);
            xfer(1 << (2 * rt), VEC[i][15:8], VEC[i][7:0], 0);
            clear_full();
        end

        // R6: data read alone, DMA off
        bus_write(1'b1, 8'h00);
        xfer(1, 8'h33, 8'hCC, 0);
        bus_read(1'b0);
        peek(1'b1, v); chk("R6 full kept without arming", v[7], 1);
        peek(1'b0, v); chk("R6 data unchanged", v, 8'hCC);
        clear_full();

        // R7: disarm on every data read
        xfer(1, 8'h44, 8'h11, 0);
        clear_full();
        xfer(1, 8'h55, 8'h22, 0);
        bus_read(1'b0);
        peek(1'b1, v); chk("R7 disarmed by earlier data read", v[7], 1);
        clear_full();

        // R8: status read while clear does not arm
        bus_write(1'b1, 8'h03);
        slave_next = 8'h66;
        bus_write(1'b0, 8'h99);
        cycles(20);
        bus_read(1'b1);
        cycles(1100);
        peek(1'b1, v); chk("R8 byte completed", v[7], 1);
        bus_read(1'b0);
        peek(1'b1, v); chk("R8 no arming from early status read", v[7], 1);
        clear_full();

        // R9: DMA mode
        bus_write(1'b1, 8'h10);
        peek(1'b1, v); chk("R11 DMA bit readback", v, 8'h50);
        xfer(1, 8'h0F, 8'hF0, 0);
        bus_read(1'b0);
        peek(1'b1, v); chk("R9 data read alone clears in DMA mode", v[7], 0);
        bus_write(1'b1, 8'h00);

        // R10: overwrite without overflow indication
        xfer(1, 8'h01, 8'hAB, 0);
        xfer(1, 8'h02, 8'hCD, 1);
        peek(1'b0, v); chk("R10 newest byte kept", v, 8'hCD);
        peek(1'b1, v); chk("R10 status has no extra bits", v, 8'hC0);
        clear_full();

        // R2: write while busy
        slave_next = 8'h77;
        bus_write(1'b0, 8'h3E);
        bus_write(1'b0, 8'hE3);
        cycles(1);
        slave_next = 8'h88;
        peek(1'b1, v); chk("R2 buffer held while busy", v[6], 0);
        cycles(14);
        peek(1'b1, v); chk("R2 still held at first completion", v[6], 0);
        chk("R5 first byte completed", v[7], 1);
        peek(1'b0, v); chk("R5 first received byte", v, 8'h77);
        cycles(1);
        peek(1'b1, v); chk("R2 buffer freed after completion", v[6], 1);
        cycles(16);
        peek(1'b0, v); chk("R3 second received byte", v, 8'h88);
        chk("R3 second shifted byte", mcap, 8'hE3);

        finished = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end
endmodule